// File: doc/BRIEF.md
# Text-Mode Video Timing Generator

This block produces the sync, blanking and position signals for a low pixel-rate raster text display. Each scan line lasts 400 pixel clocks, of which the first 320 are visible. Each frame lasts 525 lines, of which the first 480 are visible. At a 12 MHz pixel clock this gives a 30 kHz line rate and a frame rate of about 57.14 Hz. Both sync outputs are active low.

The visible lines are grouped into text rows of 10 scan lines each: 8 font lines followed by 2 forced-blank gap lines. With the default parameters this gives 48 rows of 40 eight-pixel-wide character cells. During the two gap lines of every row the block raises a gap flag and holds the display enable low. Fetch logic can use those lines to prepare the next row of character codes. A one-cycle start-of-frame pulse marks the first pixel of line 0.

The outputs come from registered counters through shallow decode logic, so every output changes in the cycle after the clock edge that moves the counters. Every count is a parameter. The requirements below use the default values.

Top module: `text_vga_timing`

## Requirements
- R1: `pixelX` counts 0 to 399 by one per clock and wraps from 399 to 0.
- R2: `lineY` advances by one each time `pixelX` wraps. It counts 0 to 524 and wraps to 0.
- R3: `hSyncN` is 0 exactly while `pixelX` is in 328..375 and is 1 otherwise.
- R4: `vSyncN` is 0 exactly while `lineY` is 490 or 491 and is 1 otherwise.
- R5: `charCol` equals `pixelX` divided by 8, rounded down, so it is 0..39 across the visible part of the line.
- R6: On a visible line (`lineY` < 480), `charRow` is `lineY`/10. `fontLine` is (`lineY` mod 10) when that value is below 8, and holds at 7 on the two gap lines. On a non-visible line, both `charRow` and `fontLine` are 0.
- R7: `rowGap` is 1 exactly when `lineY` < 480 and (`lineY` mod 10) is 8 or 9.
- R8: `displayEnable` is 1 exactly when `pixelX` < 320, `lineY` < 480 and (`lineY` mod 10) < 8. All pixel output is to be blanked whenever it is 0.
- R9: `frameStart` is 1 for exactly the one cycle in which `pixelX` and `lineY` are both 0.
- R10: While `rst` is high, and in the first cycle after it falls, `pixelX` and `lineY` are 0 and both sync outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pixelX | output | 9 | Pixel column within the line, 0..399 |
| lineY | output | 10 | Scan line within the frame, 0..524 |
| charCol | output | 6 | Character cell column |
| charRow | output | 6 | Text row index |
| fontLine | output | 3 | Font scan line within the row |
| rowGap | output | 1 | High on the two blank gap lines of each row |
| displayEnable | output | 1 | High when a pixel may be shown |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| frameStart | output | 1 | One-cycle pulse at line 0, column 0 |

## Verification
A horizontal counter off by one shows up within a single line: the sync edge moves away from column 328, or the wrap comes at the wrong column. A fault in the text-row counter does not show until the first row boundary, at line 8. From there it gives the wrong gap flag, a wrong held font index or a wrong row number. An error at the end of the visible area only appears at line 480 and at the frame wrap. So the bench follows every cycle through more than one full frame. It uses a shortened vertical layout so that these points fall within a short run, and it applies a second reset at a random time.

// File: rtl/tvga_pkg.sv
package tvga_pkg;
  localparam int DEF_H_VISIBLE = 320;
  localparam int DEF_H_FRONT = 8;
  localparam int DEF_H_SYNC = 48;
  localparam int DEF_H_BACK = 24;
  localparam int DEF_V_VISIBLE = 480;
  localparam int DEF_V_FRONT = 10;
  localparam int DEF_V_SYNC = 2;
  localparam int DEF_V_BACK = 33;
  localparam int DEF_CELL_W = 8;
  localparam int DEF_FONT_LINES = 8;
  localparam int DEF_GAP_LINES = 2;

  // Strobes from the raster counters to the text-row datapath
  typedef struct packed {
    logic lineLast;     // last pixel of a line
    logic lastVisLine;  // current line is the last visible line
    logic hVisible;
    logic vVisible;
    logic hSyncOn;
    logic vSyncOn;
    logic frameOrigin;  // pixel 0 of line 0
  } strobe_t;
endpackage

// File: rtl/tvga_ctrl.sv
module tvga_ctrl
  import tvga_pkg::*;
#(
  parameter int H_VISIBLE = DEF_H_VISIBLE,
  parameter int H_FRONT = DEF_H_FRONT,
  parameter int H_SYNC = DEF_H_SYNC,
  parameter int H_BACK = DEF_H_BACK,
  parameter int V_VISIBLE = DEF_V_VISIBLE,
  parameter int V_FRONT = DEF_V_FRONT,
  parameter int V_SYNC = DEF_V_SYNC,
  parameter int V_BACK = DEF_V_BACK,
  localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_VISIBLE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output strobe_t       strobes
);
  localparam int HS_START = H_VISIBLE + H_FRONT;
  localparam int VS_START = V_VISIBLE + V_FRONT;

  logic hLast;
  logic vLast;

  assign hLast = (hCount == HW'(H_TOTAL - 1));
  assign vLast = (vCount == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (hLast) begin
      hCount <= '0;
      vCount <= vLast ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  always_comb begin
    strobes.lineLast    = hLast;
    strobes.lastVisLine = (vCount == VW'(V_VISIBLE - 1));
    strobes.hVisible    = (hCount < HW'(H_VISIBLE));
    strobes.vVisible    = (vCount < VW'(V_VISIBLE));
    strobes.hSyncOn     = (hCount >= HW'(HS_START)) && (hCount < HW'(HS_START + H_SYNC));
    strobes.vSyncOn     = (vCount >= VW'(VS_START)) && (vCount < VW'(VS_START + V_SYNC));
    strobes.frameOrigin = (hCount == '0) && (vCount == '0);
  end

  assert_h_range_R1: assert property (@(posedge clk) disable iff (rst)
    hCount < HW'(H_TOTAL));
  assert_line_step_R2: assert property (@(posedge clk) disable iff (rst)
    (hCount != '0) |=> ($stable(vCount) || $past(hCount) == HW'(H_TOTAL - 1)));
  assert_v_range_R2: assert property (@(posedge clk) disable iff (rst)
    vCount < VW'(V_TOTAL));
endmodule

// File: rtl/tvga_rows.sv
module tvga_rows
  import tvga_pkg::*;
#(
  parameter int V_VISIBLE = DEF_V_VISIBLE,
  parameter int FONT_LINES = DEF_FONT_LINES,
  parameter int GAP_LINES = DEF_GAP_LINES,
  localparam int ROW_LINES = FONT_LINES + GAP_LINES,
  localparam int ROWS = V_VISIBLE / ROW_LINES,
  localparam int SW = $clog2(ROW_LINES),
  localparam int RW = $clog2(ROWS),
  localparam int FW = $clog2(FONT_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strobes,
  output logic [FW-1:0] fontLine,
  output logic [RW-1:0] charRow,
  output logic          rowGap,
  output logic          displayEnable,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          frameStart
);
  logic [SW-1:0] subLine;
  logic          inGap;

  always_ff @(posedge clk) begin
    if (rst) begin
      subLine <= '0;
      charRow <= '0;
    end else if (strobes.lineLast) begin
      if (strobes.lastVisLine) begin
        subLine <= '0;
        charRow <= '0;
      end else if (strobes.vVisible) begin
        if (subLine == SW'(ROW_LINES - 1)) begin
          subLine <= '0;
          charRow <= charRow + 1'b1;
        end else begin
          subLine <= subLine + 1'b1;
        end
      end
    end
  end

  assign inGap = (subLine >= SW'(FONT_LINES));

  always_comb begin
    rowGap        = strobes.vVisible && inGap;
    fontLine      = inGap ? FW'(FONT_LINES - 1) : FW'(subLine);
    displayEnable = strobes.hVisible && strobes.vVisible && !inGap;
    hSyncN        = !strobes.hSyncOn;
    vSyncN        = !strobes.vSyncOn;
    frameStart    = strobes.frameOrigin;
  end

  assert_gap_blank_R8: assert property (@(posedge clk) disable iff (rst)
    rowGap |-> !displayEnable);
  assert_gap_font_hold_R6: assert property (@(posedge clk) disable iff (rst)
    rowGap |-> (fontLine == FW'(FONT_LINES - 1)));
  assert_frame_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);
  assert_gap_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rowGap) |-> (fontLine == '0));
endmodule

// File: rtl/text_vga_timing.sv
module text_vga_timing
  import tvga_pkg::*;
#(
  parameter int H_VISIBLE = DEF_H_VISIBLE,
  parameter int H_FRONT = DEF_H_FRONT,
  parameter int H_SYNC = DEF_H_SYNC,
  parameter int H_BACK = DEF_H_BACK,
  parameter int V_VISIBLE = DEF_V_VISIBLE,
  parameter int V_FRONT = DEF_V_FRONT,
  parameter int V_SYNC = DEF_V_SYNC,
  parameter int V_BACK = DEF_V_BACK,
  parameter int CELL_W = DEF_CELL_W,
  parameter int FONT_LINES = DEF_FONT_LINES,
  parameter int GAP_LINES = DEF_GAP_LINES,
  localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_VISIBLE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL),
  localparam int CW = $clog2(H_VISIBLE / CELL_W),
  localparam int RW = $clog2(V_VISIBLE / (FONT_LINES + GAP_LINES)),
  localparam int FW = $clog2(FONT_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] pixelX,
  output logic [VW-1:0] lineY,
  output logic [CW-1:0] charCol,
  output logic [RW-1:0] charRow,
  output logic [FW-1:0] fontLine,
  output logic          rowGap,
  output logic          displayEnable,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          frameStart
);
  strobe_t strobes;

  tvga_ctrl #(
    .H_VISIBLE(H_VISIBLE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_VISIBLE(V_VISIBLE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) i_ctrl (
    .clk(clk), .rst(rst), .hCount(pixelX), .vCount(lineY), .strobes(strobes)
  );

  tvga_rows #(
    .V_VISIBLE(V_VISIBLE), .FONT_LINES(FONT_LINES), .GAP_LINES(GAP_LINES)
  ) i_rows (
    .clk(clk), .rst(rst), .strobes(strobes), .fontLine(fontLine), .charRow(charRow),
    .rowGap(rowGap), .displayEnable(displayEnable), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .frameStart(frameStart)
  );

  assign charCol = CW'(pixelX / HW'(CELL_W));

  assert_hsync_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(hSyncN) |-> (pixelX == HW'(H_VISIBLE + H_FRONT)));
  assert_vsync_window_R4: assert property (@(posedge clk) disable iff (rst)
    !vSyncN |-> (lineY >= VW'(V_VISIBLE + V_FRONT)) && (lineY < VW'(V_VISIBLE + V_FRONT + V_SYNC)));
  assert_enable_area_R8: assert property (@(posedge clk) disable iff (rst)
    displayEnable |-> (pixelX < HW'(H_VISIBLE)) && (lineY < VW'(V_VISIBLE)));
  assert_frame_origin_R9: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (pixelX == '0) && (lineY == '0));
endmodule

// File: tb/test_text_vga_timing.sv
`timescale 1ns/1ps
module test_text_vga_timing;
  // Shortened vertical layout so a whole frame fits in a short run
  localparam int HV = 320, HF = 8, HS = 48, HB = 24;
  localparam int VV = 60, VF = 10, VS = 2, VB = 33;
  localparam int CELL = 8, FL = 8, GL = 2;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int RL = FL + GL;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam int CW = $clog2(HV / CELL);
  localparam int RW = $clog2(VV / RL);
  localparam int FW = $clog2(FL);

  logic clk = 0;
  logic rst = 1;
  logic [HW-1:0] pixelX;
  logic [VW-1:0] lineY;
  logic [CW-1:0] charCol;
  logic [RW-1:0] charRow;
  logic [FW-1:0] fontLine;
  logic rowGap, displayEnable, hSyncN, vSyncN, frameStart;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  text_vga_timing #(
    .H_VISIBLE(HV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_VISIBLE(VV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .CELL_W(CELL), .FONT_LINES(FL), .GAP_LINES(GL)
  ) i_text_vga_timing (
    .clk(clk), .rst(rst), .pixelX(pixelX), .lineY(lineY), .charCol(charCol),
    .charRow(charRow), .fontLine(fontLine), .rowGap(rowGap),
    .displayEnable(displayEnable), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .frameStart(frameStart)
  );

  task automatic check(string req, string what, int act, int exp, int n);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, n, act, exp);
    end
  endtask

  function automatic int expRow(int y);
    return (y < VV) ? y / RL : 0;
  endfunction
  function automatic int expFont(int y);
    if (y >= VV) return 0;
    return ((y % RL) < FL) ? (y % RL) : FL - 1;
  endfunction
  function automatic int expGap(int y);
    return (y < VV && (y % RL) >= FL) ? 1 : 0;
  endfunction
  function automatic int expEn(int x, int y);
    return (x < HV && y < VV && (y % RL) < FL) ? 1 : 0;
  endfunction

  // n = cycles since reset release
  task automatic checkAll(int n);
    int x = n % HT;
    int y = (n / HT) % VT;
    check("R1", "pixelX", int'(pixelX), x, n);
    check("R2", "lineY", int'(lineY), y, n);
    check("R3", "hSyncN", int'(hSyncN), (x >= HV + HF && x < HV + HF + HS) ? 0 : 1, n);
    check("R4", "vSyncN", int'(vSyncN), (y >= VV + VF && y < VV + VF + VS) ? 0 : 1, n);
    check("R5", "charCol", int'(charCol), x / CELL, n);
    check("R6", "charRow", int'(charRow), expRow(y), n);
    check("R6", "fontLine", int'(fontLine), expFont(y), n);
    check("R7", "rowGap", int'(rowGap), expGap(y), n);
    check("R8", "displayEnable", int'(displayEnable), expEn(x, y), n);
    check("R9", "frameStart", int'(frameStart), (x == 0 && y == 0) ? 1 : 0, n);
  endtask

  task automatic runCycles(int count);
    for (int n = 1; n <= count; n++) begin
      @(negedge clk);
      checkAll(n);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    // R10: values while reset is held
    check("R10", "pixelX in reset", int'(pixelX), 0, 0);
    check("R10", "lineY in reset", int'(lineY), 0, 0);
    check("R10", "hSyncN in reset", int'(hSyncN), 1, 0);
    check("R10", "vSyncN in reset", int'(vSyncN), 1, 0);
    rst = 0;
    #1;
    check("R10", "pixelX after release", int'(pixelX), 0, 0);
    check("R10", "hSyncN after release", int'(hSyncN), 1, 0);
    checkAll(0);
  endtask

  initial begin
    int firstRun;
    void'($urandom(32'd20240611));
    firstRun = 5000 + int'($urandom % 30000);
    doReset();
    runCycles(firstRun);
    doReset();
    runCycles(2 * HT * VT + 3 * HT + 17);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule